// File: doc/BRIEF.md
# Instrumentation Trace Control Register Access Checker

This block sits on the system-register access path for a small control register that holds two trace-enable bits. One bit permits instrumentation trace at the kernel privilege level (EL1) and the other permits it at the user level (EL0). Each request carries an instruction encoding, a read or write direction, the current privilege level and 64 bits of write data. The block decides what the access does: it may be undefined, trap to EL2, trap to EL3, be redirected to a nested-virtualisation memory slot, be redirected to a companion EL2 register, or reach the register directly.

The decision is not a plain read/write. A fixed priority chain weighs the configuration inputs. These come from the higher exception levels and cover whether EL2 is enabled, whether EL3 exists, debug halt, secure-debug disable, the EL3 trace-access enable, fine-grained trap controls, the nested-virtualisation bits and the host-mode bit. The chain differs between the main encoding and its alias. The block returns one registered response per claimed request. The response has a one-hot outcome, a syndrome class for traps, a memory offset for redirects and read data for direct reads. The block owns the two enable bits and drives them out continuously.

Top module: `trc_ite_ctl`

## Requirements
- R1: After reset the two enable bits are 0 and rspValid is low.
- R2: The block claims a request (reqValid high) when reqEnc = {op0[15:14], op1[13:11], CRn[10:7], CRm[6:3], op2[2:0]} equals the main encoding 16'hC093 or the alias 16'hE893. One cycle later it raises rspValid for one cycle with exactly one rspOutcome bit set: bit0 undefined, bit1 trap to EL2, bit2 trap to EL3, bit3 memory redirect, bit4 companion redirect, bit5 direct access. An unclaimed encoding gives no response, and rspOutcome is 0 whenever rspValid is low.
- R3: A claimed request at level 0 (EL0) is undefined under either encoding.
- R4: At EL1 on the main encoding, the first matching rule wins. (a) Halted, EL3 present, secure debug disabled, the priority-pick flag set and the EL3 enable clear gives undefined. (b) EL2 enabled, fine-grained traps supported, EL3 present and the EL3 fine-grained enable clear gives a trap to EL2. (c) EL2 enabled, fine-grained traps supported and the direction's trap bit clear (cfgFgtRd for reads, cfgFgtWr for writes) gives a trap to EL2. (d) EL3 present and the EL3 enable clear gives undefined when halted with secure debug disabled, and a trap to EL3 otherwise. (e) EL2 enabled with cfgNv = {NV2,NV1,NV} = 3'b111 gives a memory redirect. (f) Anything else is direct access.
- R5: rspClass is 6'h18 on both trap outcomes and 0 on every other outcome.
- R6: rspMemOffset is 12'h888 on a memory redirect and 0 on every other outcome.
- R7: At EL2 on the main encoding, rules (a) and (d) apply first. After them, host mode set gives a companion redirect and host mode clear gives direct access. The fine-grained and nested-virtualisation inputs are ignored.
- R8: At EL3 on the main encoding, the access is always direct.
- R9: At EL1 on the alias encoding, EL2 enabled with cfgNv = 3'b101 gives a memory redirect. Otherwise EL2 enabled with NV (cfgNv[0]) set gives a trap to EL2. Otherwise the access is undefined.
- R10: At EL2 on the alias encoding, host mode clear is undefined. With host mode set, rules (a) and (d) apply, and otherwise the access is direct. At EL3 on the alias encoding, the access is direct only when EL2 is enabled, EL2 runs 64-bit (cfgEl2A64) and host mode is set. Otherwise it is undefined.
- R11: A write whose outcome is direct access loads reqWdata[1:0] into the register. Every other write leaves it unchanged. A direct read returns the register zero-extended to 64 bits. rspRdata is 0 for every other outcome.
- R12: traceEnEl1 and traceEnEl0 drive register bits 1 and 0 at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Access request strobe |
| reqEnc | input | 16 | Instruction encoding fields |
| reqWrite | input | 1 | 1 write, 0 read |
| reqLevel | input | 2 | Current privilege level 0..3 |
| reqWdata | input | 64 | Write data |
| cfgEl2En | input | 1 | EL2 enabled in current security state |
| cfgEl3Present | input | 1 | EL3 implemented |
| cfgHalted | input | 1 | Core in debug halt |
| cfgSecDbgDis | input | 1 | Secure debug disabled |
| cfgPrioPick | input | 1 | Implementation choice: early undefined while halted |
| cfgEl3Enable | input | 1 | EL3 permission for trace-control access |
| cfgFgtSup | input | 1 | Fine-grained traps supported |
| cfgEl3FgtEn | input | 1 | EL3 enable for fine-grained traps |
| cfgFgtRd | input | 1 | Per-register read trap bit (0 traps) |
| cfgFgtWr | input | 1 | Per-register write trap bit (0 traps) |
| cfgNv | input | 3 | {NV2, NV1, NV} |
| cfgHost | input | 1 | Host mode at EL2 |
| cfgEl2A64 | input | 1 | EL2 runs 64-bit |
| rspValid | output | 1 | Response strobe |
| rspOutcome | output | 6 | One-hot outcome |
| rspClass | output | 6 | Syndrome exception class |
| rspMemOffset | output | 12 | Redirect memory offset |
| rspRdata | output | 64 | Read data |
| traceEnEl1 | output | 1 | Trace permitted at EL1 |
| traceEnEl0 | output | 1 | Trace permitted at EL0 |

## Verification
The priority chain is tried with configurations that each turn on two competing rules at once. Examples are a halted EL3 block with and without the priority-pick flag, a fine-grained bit clear with fine-grained support absent, and nested-virtualisation bits set with EL2 disabled. Each such pair shows whether the right rule wins. Read and write directions are run against opposite trap bits to show that the direction picks the bit. Writes of all-ones data under every non-direct outcome, each followed by a direct read, show that the register changes only on direct access and that the upper bits are dropped.

// File: rtl/itc_pkg.sv
package itc_pkg;
  localparam int ENC_W   = 16;
  localparam int OUT_N   = 6;
  localparam int CLASS_W = 6;
  localparam int OFF_W   = 12;

  localparam logic [ENC_W-1:0]   ENC_MAIN  = 16'hC093;
  localparam logic [ENC_W-1:0]   ENC_ALIAS = 16'hE893;
  localparam logic [CLASS_W-1:0] EC_SYSREG = 6'h18;
  localparam logic [OFF_W-1:0]   NV_OFFSET = 12'h888;

  // outcome bit positions
  localparam int O_UND = 0;
  localparam int O_T2  = 1;
  localparam int O_T3  = 2;
  localparam int O_MEM = 3;
  localparam int O_CMP = 4;
  localparam int O_DIR = 5;

  typedef struct packed {
    logic wrEn;
    logic rdEn;
  } itcStrobe_t;
endpackage

// File: rtl/itc_ctrl.sv
module itc_ctrl
  import itc_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqValid,
  input  logic [ENC_W-1:0]   reqEnc,
  input  logic               reqWrite,
  input  logic [1:0]         reqLevel,
  input  logic               cfgEl2En,
  input  logic               cfgEl3Present,
  input  logic               cfgHalted,
  input  logic               cfgSecDbgDis,
  input  logic               cfgPrioPick,
  input  logic               cfgEl3Enable,
  input  logic               cfgFgtSup,
  input  logic               cfgEl3FgtEn,
  input  logic               cfgFgtRd,
  input  logic               cfgFgtWr,
  input  logic [2:0]         cfgNv,
  input  logic               cfgHost,
  input  logic               cfgEl2A64,
  output itcStrobe_t         stb,
  output logic               rspValid,
  output logic [OUT_N-1:0]   rspOutcome,
  output logic [CLASS_W-1:0] rspClass,
  output logic [OFF_W-1:0]   rspMemOffset
);
  logic isMain, isAlias, claimed;
  logic haltPrioUnd, el3Block, el3Und, fgtBit;
  logic [OUT_N-1:0] nextOut;

  assign isMain  = (reqEnc == ENC_MAIN);
  assign isAlias = (reqEnc == ENC_ALIAS);
  assign claimed = reqValid && (isMain || isAlias);

  assign haltPrioUnd = cfgHalted && cfgEl3Present && cfgSecDbgDis && cfgPrioPick && !cfgEl3Enable;
  assign el3Block    = cfgEl3Present && !cfgEl3Enable;
  assign el3Und      = cfgHalted && cfgSecDbgDis;
  assign fgtBit      = reqWrite ? cfgFgtWr : cfgFgtRd;

  always_comb begin
    nextOut = '0;
    if (isMain) begin
      unique case (reqLevel)
        2'd0: nextOut[O_UND] = 1'b1;
        2'd1: begin
          if (haltPrioUnd)                                     nextOut[O_UND] = 1'b1;
          else if (cfgEl2En && cfgFgtSup && cfgEl3Present && !cfgEl3FgtEn) nextOut[O_T2] = 1'b1;
          else if (cfgEl2En && cfgFgtSup && !fgtBit)           nextOut[O_T2] = 1'b1;
          else if (el3Block)                                   nextOut[el3Und ? O_UND : O_T3] = 1'b1;
          else if (cfgEl2En && cfgNv == 3'b111)                nextOut[O_MEM] = 1'b1;
          else                                                 nextOut[O_DIR] = 1'b1;
        end
        2'd2: begin
          if (haltPrioUnd)   nextOut[O_UND] = 1'b1;
          else if (el3Block) nextOut[el3Und ? O_UND : O_T3] = 1'b1;
          else if (cfgHost)  nextOut[O_CMP] = 1'b1;
          else               nextOut[O_DIR] = 1'b1;
        end
        default: nextOut[O_DIR] = 1'b1;
      endcase
    end else begin
      unique case (reqLevel)
        2'd0: nextOut[O_UND] = 1'b1;
        2'd1: begin
          if (cfgEl2En && cfgNv == 3'b101)  nextOut[O_MEM] = 1'b1;
          else if (cfgEl2En && cfgNv[0])    nextOut[O_T2] = 1'b1;
          else                              nextOut[O_UND] = 1'b1;
        end
        2'd2: begin
          if (!cfgHost || haltPrioUnd) nextOut[O_UND] = 1'b1;
          else if (el3Block)           nextOut[el3Und ? O_UND : O_T3] = 1'b1;
          else                         nextOut[O_DIR] = 1'b1;
        end
        default: begin
          if (cfgEl2En && cfgEl2A64 && cfgHost) nextOut[O_DIR] = 1'b1;
          else                                  nextOut[O_UND] = 1'b1;
        end
      endcase
    end
  end

  always_comb begin
    stb.wrEn = claimed && nextOut[O_DIR] && reqWrite;
    stb.rdEn = claimed && nextOut[O_DIR] && !reqWrite;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid     <= 1'b0;
      rspOutcome   <= '0;
      rspClass     <= '0;
      rspMemOffset <= '0;
    end else begin
      rspValid     <= claimed;
      rspOutcome   <= claimed ? nextOut : '0;
      rspClass     <= (claimed && (nextOut[O_T2] || nextOut[O_T3])) ? EC_SYSREG : '0;
      rspMemOffset <= (claimed && nextOut[O_MEM]) ? NV_OFFSET : '0;
    end
  end
endmodule

// File: rtl/itc_dpath.sv
module itc_dpath
  import itc_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int REG_W  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  itcStrobe_t        stb,
  input  logic [REG_W-1:0]  wrBits,
  output logic [DATA_W-1:0] rspRdata,
  output logic [REG_W-1:0]  regBits
);
  localparam int PAD_W = DATA_W - REG_W;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      regBits  <= '0;
      rspRdata <= '0;
    end else begin
      if (stb.wrEn) regBits <= wrBits;
      rspRdata <= stb.rdEn ? {{PAD_W{1'b0}}, regBits} : '0;
    end
  end
endmodule

// File: rtl/trc_ite_ctl.sv
module trc_ite_ctl
  import itc_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int REG_W  = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqValid,
  input  logic [ENC_W-1:0]   reqEnc,
  input  logic               reqWrite,
  input  logic [1:0]         reqLevel,
  input  logic [DATA_W-1:0]  reqWdata,
  input  logic               cfgEl2En,
  input  logic               cfgEl3Present,
  input  logic               cfgHalted,
  input  logic               cfgSecDbgDis,
  input  logic               cfgPrioPick,
  input  logic               cfgEl3Enable,
  input  logic               cfgFgtSup,
  input  logic               cfgEl3FgtEn,
  input  logic               cfgFgtRd,
  input  logic               cfgFgtWr,
  input  logic [2:0]         cfgNv,
  input  logic               cfgHost,
  input  logic               cfgEl2A64,
  output logic               rspValid,
  output logic [OUT_N-1:0]   rspOutcome,
  output logic [CLASS_W-1:0] rspClass,
  output logic [OFF_W-1:0]   rspMemOffset,
  output logic [DATA_W-1:0]  rspRdata,
  output logic               traceEnEl1,
  output logic               traceEnEl0
);
  itcStrobe_t       stb;
  logic [REG_W-1:0] regBits;

  itc_ctrl u_ctrl (
    .clk, .rstN, .reqValid, .reqEnc, .reqWrite, .reqLevel,
    .cfgEl2En, .cfgEl3Present, .cfgHalted, .cfgSecDbgDis, .cfgPrioPick,
    .cfgEl3Enable, .cfgFgtSup, .cfgEl3FgtEn, .cfgFgtRd, .cfgFgtWr,
    .cfgNv, .cfgHost, .cfgEl2A64,
    .stb, .rspValid, .rspOutcome, .rspClass, .rspMemOffset
  );

  itc_dpath #(.DATA_W(DATA_W), .REG_W(REG_W)) u_dpath (
    .clk, .rstN, .stb,
    .wrBits   (reqWdata[REG_W-1:0]),
    .rspRdata (rspRdata),
    .regBits  (regBits)
  );

  assign traceEnEl1 = regBits[1];
  assign traceEnEl0 = regBits[0];
endmodule

// File: rtl/trc_ite_ctl_chk.sv
module trc_ite_ctl_chk
  import itc_pkg::*;
(
  input logic               clk,
  input logic               rstN,
  input logic               reqValid,
  input logic [ENC_W-1:0]   reqEnc,
  input logic [1:0]         reqLevel,
  input logic               rspValid,
  input logic [OUT_N-1:0]   rspOutcome,
  input logic [CLASS_W-1:0] rspClass,
  input logic [OFF_W-1:0]   rspMemOffset,
  input logic               traceEnEl1,
  input logic               traceEnEl0
);
  // R2
  resp_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> $onehot(rspOutcome));
  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !rspValid |-> rspOutcome == '0);
  // R3
  el0_undef_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && (reqEnc == ENC_MAIN || reqEnc == ENC_ALIAS) && reqLevel == 2'd0)
      |=> (rspValid && rspOutcome[O_UND]));
  // R5
  trap_class_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && (rspOutcome[O_T2] || rspOutcome[O_T3])) |-> rspClass == EC_SYSREG);
  // R6
  mem_offset_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspOutcome[O_MEM]) |-> rspMemOffset == NV_OFFSET);
  // R8
  el3_main_direct_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqEnc == ENC_MAIN && reqLevel == 2'd3) |=> rspOutcome[O_DIR]);
  // R11
  reg_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable({traceEnEl1, traceEnEl0}) |-> (rspValid && rspOutcome[O_DIR]));
endmodule

bind trc_ite_ctl trc_ite_ctl_chk u_chk (
  .clk, .rstN, .reqValid, .reqEnc, .reqLevel, .rspValid, .rspOutcome,
  .rspClass, .rspMemOffset, .traceEnEl1, .traceEnEl0
);

// File: tb/trc_ite_ctl_tb.sv
module trc_ite_ctl_tb;
  localparam logic [15:0] MAIN  = 16'hC093;
  localparam logic [15:0] ALIAS = 16'hE893;
  // cfg word: 14 el2En,13 el3P,12 halt,11 sdd,10 prio,9 en3,8 fgtSup,7 el3Fgt,6 fgtRd,5 fgtWr,4:2 nv,1 host,0 a64
  localparam logic [14:0] M_EL2 = 15'h4000, M_EL3P = 15'h2000, M_HLT = 15'h1000,
    M_SDD = 15'h0800, M_PRI = 15'h0400, M_EN3 = 15'h0200, M_FSUP = 15'h0100,
    M_EFGT = 15'h0080, M_FRD = 15'h0040, M_FWR = 15'h0020, M_NV111 = 15'h001C,
    M_NV101 = 15'h0014, M_NV110 = 15'h0018, M_HOST = 15'h0002, M_A64 = 15'h0001;
  localparam logic [14:0] BASE = M_EL2 | M_EL3P | M_EN3 | M_FSUP | M_EFGT | M_FRD | M_FWR | M_A64;
  localparam logic [5:0] UND = 6'h01, T2 = 6'h02, T3 = 6'h04, MEM = 6'h08, CMP = 6'h10, DIR = 6'h20;

  function automatic logic [24:0] vec(input logic al, input logic [1:0] lv, input logic wr,
                                      input logic [14:0] cf, input logic [5:0] ex);
    return {al, lv, wr, cf, ex};
  endfunction

  localparam int NV = 30;
  localparam logic [24:0] VECS [NV] = '{
    vec(0, 0, 0, BASE, UND),                                     // R3
    vec(1, 0, 1, BASE, UND),                                     // R3
    vec(0, 1, 0, BASE, DIR),                                     // R4
    vec(0, 1, 0, (BASE | M_HLT | M_SDD | M_PRI) & ~M_EN3, UND),  // R4 a
    vec(0, 1, 0, (BASE | M_HLT | M_SDD) & ~M_EN3 & ~M_EFGT, T2), // R4 b
    vec(0, 1, 0, BASE & ~M_FRD, T2),                             // R4 c
    vec(0, 1, 1, BASE & ~M_FRD, DIR),                            // R4 c write uses wr bit
    vec(0, 1, 1, BASE & ~M_FWR, T2),                             // R4 c
    vec(0, 1, 0, BASE & ~M_FSUP & ~M_EFGT & ~M_FRD, DIR),        // R4 no fgt support
    vec(0, 1, 0, BASE & ~M_EN3, T3),                             // R4 d
    vec(0, 1, 0, (BASE | M_HLT | M_SDD) & ~M_EN3, UND),          // R4 d halted
    vec(0, 1, 0, BASE & ~M_EL2 & ~M_FRD & ~M_EN3, T3),           // R4 el2 off
    vec(0, 1, 0, BASE | M_NV111, MEM),                           // R4 e
    vec(0, 1, 0, (BASE & ~M_EL2) | M_NV111, DIR),                // R4 e el2 off
    vec(0, 1, 0, BASE | M_NV110, DIR),                           // R4 f
    vec(0, 2, 0, BASE | M_HOST, CMP),                            // R7
    vec(0, 2, 0, (BASE | M_HOST) & ~M_EN3, T3),                  // R7
    vec(0, 2, 0, (BASE | M_HLT | M_SDD | M_PRI) & ~M_EN3, UND),  // R7
    vec(0, 2, 0, (BASE | M_NV111) & ~M_FRD, DIR),                // R7
    vec(0, 3, 0, BASE & ~M_EN3, DIR),                            // R8
    vec(1, 1, 0, BASE | M_NV101, MEM),                           // R9
    vec(1, 1, 0, BASE | M_NV111, T2),                            // R9
    vec(1, 1, 0, (BASE & ~M_EL2) | M_NV101, UND),                // R9
    vec(1, 1, 0, BASE, UND),                                     // R9
    vec(1, 2, 0, BASE, UND),                                     // R10
    vec(1, 2, 0, BASE | M_HOST, DIR),                            // R10
    vec(1, 2, 0, (BASE | M_HOST) & ~M_EN3, T3),                  // R10
    vec(1, 3, 0, BASE | M_HOST, DIR),                            // R10
    vec(1, 3, 0, (BASE | M_HOST) & ~M_A64, UND),                 // R10
    vec(1, 3, 0, BASE, UND)                                      // R10
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic [15:0] reqEnc = '0;
  logic reqWrite = 1'b0;
  logic [1:0] reqLevel = '0;
  logic [63:0] reqWdata = '0;
  logic [14:0] cfg = BASE;
  logic rspValid, traceEnEl1, traceEnEl0;
  logic [5:0] rspOutcome, rspClass;
  logic [11:0] rspMemOffset;
  logic [63:0] rspRdata;
  int nChk = 0, nFail = 0;
  logic finished = 1'b0;

  always #2 clk = ~clk;

  trc_ite_ctl u_dut (
    .clk, .rstN, .reqValid, .reqEnc, .reqWrite, .reqLevel, .reqWdata,
    .cfgEl2En(cfg[14]), .cfgEl3Present(cfg[13]), .cfgHalted(cfg[12]),
    .cfgSecDbgDis(cfg[11]), .cfgPrioPick(cfg[10]), .cfgEl3Enable(cfg[9]),
    .cfgFgtSup(cfg[8]), .cfgEl3FgtEn(cfg[7]), .cfgFgtRd(cfg[6]), .cfgFgtWr(cfg[5]),
    .cfgNv(cfg[4:2]), .cfgHost(cfg[1]), .cfgEl2A64(cfg[0]),
    .rspValid, .rspOutcome, .rspClass, .rspMemOffset, .rspRdata, .traceEnEl1, .traceEnEl0
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // drive at negedge, response visible at the following negedge
  task automatic access(input logic [15:0] enc, input logic [1:0] lv, input logic wr,
                        input logic [14:0] cf, input logic [63:0] wd);
    @(negedge clk);
    reqValid = 1'b1; reqEnc = enc; reqLevel = lv; reqWrite = wr; cfg = cf; reqWdata = wd;
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  initial begin
    #700000;
    if (!finished) begin
      nChk++; nFail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 valid", {63'b0, rspValid}, 64'd0);
    check("R1 reg", {62'b0, traceEnEl1, traceEnEl0}, 64'd0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 valid after release", {63'b0, rspValid}, 64'd0);

    for (int i = 0; i < NV; i++) begin
      logic [24:0] v;
      logic [5:0] ex;
      v = VECS[i];
      ex = v[5:0];
      access(v[24] ? ALIAS : MAIN, v[23:22], v[21], v[20:6], 64'd0);
      check($sformatf("R2 R4 R7 R8 R9 R10 vec%0d valid", i), {63'b0, rspValid}, 64'd1);
      check($sformatf("R2 R4 R7 R8 R9 R10 vec%0d outcome", i), {58'b0, rspOutcome}, {58'b0, ex});
      check($sformatf("R5 vec%0d class", i), {58'b0, rspClass}, (ex == T2 || ex == T3) ? 64'h18 : 64'h0);
      check($sformatf("R6 vec%0d offset", i), {52'b0, rspMemOffset}, (ex == MEM) ? 64'h888 : 64'h0);
      @(negedge clk);
      check($sformatf("R2 vec%0d one-cycle", i), {58'b0, rspValid, rspOutcome}, 64'd0);
    end

    // R2 unclaimed encoding
    access(16'hC094, 2'd3, 1'b1, BASE, 64'h3);
    check("R2 unclaimed no response", {63'b0, rspValid}, 64'd0);
    check("R2 unclaimed no write", {62'b0, traceEnEl1, traceEnEl0}, 64'd0);

    // R11 direct write drops upper bits; R12 outputs follow
    access(MAIN, 2'd3, 1'b1, BASE, 64'hFFFF_FFFF_FFFF_FFFD);
    check("R12 enables after write", {62'b0, traceEnEl1, traceEnEl0}, 64'd1);
    check("R11 write rdata zero", rspRdata, 64'd0);
    access(MAIN, 2'd1, 1'b0, BASE, 64'd0);
    check("R11 direct read", rspRdata, 64'd1);

    // R11 non-direct writes leave the register alone
    access(MAIN, 2'd1, 1'b1, BASE & ~M_FWR, 64'hFFFF_FFFF_FFFF_FFFF);
    check("R11 trap2 write ignored", {62'b0, traceEnEl1, traceEnEl0}, 64'd1);
    access(MAIN, 2'd1, 1'b1, BASE & ~M_EN3, 64'h2);
    check("R11 trap3 write ignored", {62'b0, traceEnEl1, traceEnEl0}, 64'd1);
    access(MAIN, 2'd2, 1'b1, BASE | M_HOST, 64'h2);
    check("R11 companion write ignored", {62'b0, traceEnEl1, traceEnEl0}, 64'd1);
    access(MAIN, 2'd1, 1'b1, BASE | M_NV111, 64'h2);
    check("R11 mem write ignored", {62'b0, traceEnEl1, traceEnEl0}, 64'd1);
    access(ALIAS, 2'd0, 1'b1, BASE, 64'h2);
    check("R11 undef write ignored", {62'b0, traceEnEl1, traceEnEl0}, 64'd1);
    access(MAIN, 2'd1, 1'b0, BASE | M_NV111, 64'd0);
    check("R11 mem read rdata zero", rspRdata, 64'd0);

    // R11 alias direct write at EL2 host
    access(ALIAS, 2'd2, 1'b1, BASE | M_HOST, 64'h8000_0000_0000_0002);
    check("R12 el1 enable", {63'b0, traceEnEl1}, 64'd1);
    check("R12 el0 enable", {63'b0, traceEnEl0}, 64'd0);
    access(ALIAS, 2'd3, 1'b0, BASE | M_HOST, 64'd0);
    check("R11 alias read", rspRdata, 64'd2);

    // R1 reset clears register
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    check("R1 reset clears reg", {62'b0, traceEnEl1, traceEnEl0}, 64'd0);
    rstN = 1'b1;

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end
endmodule